// File: doc/BRIEF.md
# I2C Target Register-Access Controller

This block is an I2C target that runs entirely from a fast system clock. Both bus lines pass through two-flop synchronizers, and an edge stage finds SCL edges together with the Start and Stop conditions. A byte engine shifts bits MSB first, compares the address byte with a fixed upper nibble of binary 0100 followed by three strap inputs, and acknowledges each byte. It drives the bus only through an open-drain pull-low enable.

The registers sit outside the block. After the address, the first byte of a write is a command byte. Its two low bits choose one of four 8-bit registers: 0 is input, 1 is output, 2 is polarity inversion and 3 is configuration. The choice stays in effect across any number of data bytes, across repeated Starts and across later transactions, and only a new command byte changes it. The register side receives a write strobe with data for each byte written. For reads, the block samples a read-data input and returns a strobe for each byte it sends.

Top module: `i2ct_target`

## Requirements
- R1: After reset, sda_oe is 0, reg_wr_en and reg_rd_ack are 0, and reg_sel is 0.
- R2: An address byte whose upper seven bits equal binary 0100 followed by strap_addr[2:0] is acknowledged. The target holds sda_oe at 1 through the whole SCL-high phase of the ninth clock. Bit 0 of the address byte selects the direction, with 1 meaning read.
- R3: An address that does not match is not acknowledged. Until the next Start or Stop, sda_oe stays 0, no strobe is issued and reg_sel does not change.
- R4: The first byte after a write address is a command byte. Its bits [1:0] become reg_sel, and its bits [7:2] are ignored.
- R5: Each data byte that follows the command byte in a write produces one reg_wr_en pulse. The pulse carries the byte on reg_wr_data and uses the same reg_sel every time, with no increment.
- R6: The reg_wr_en pulse for a byte occurs after SCL rises in that byte's ACK clock, while SCL is still high.
- R7: A data byte written while reg_sel is 0 (the input register) is still acknowledged but produces no reg_wr_en pulse.
- R8: Each read byte is reg_rd_data for the current reg_sel, sent MSB first. The same register is sent for every byte the controller acknowledges, including after a repeated Start. With no prior command byte, the register read is register 0.
- R9: reg_rd_ack pulses once per read byte, at the SCL rise of that byte's ACK/NACK clock.
- R10: When the controller NACKs a read byte, the target releases SDA (sda_oe is 0) and keeps it released until the next Start.
- R11: sda_oe goes from 0 to 1 only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| strap_addr | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel | output | 2 | Currently selected register |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_data | input | 8 | Value of the selected register |
| reg_rd_ack | output | 1 | One-cycle strobe per read byte |

## Verification
A change on a bus line reaches the registered outputs three system clocks later: two synchronizer flops, then the registered edge stage feeding the FSM. The bench holds each SCL phase for eight clocks. It drives new SDA values a few clocks into the low phase and samples the wired-AND line four clocks into the high phase, so the acknowledge and data bits are always read after they have settled. Write and read strobes are gathered by a monitor on every clock and compared with the bytes the bench expects. A second per-clock check confirms that every rise of sda_oe falls in an SCL-low window.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 2;
    localparam int STRAP_W   = 3;
    localparam int PREFIX_W  = 7 - STRAP_W;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b0100;
    localparam logic [SEL_W-1:0]    SEL_INPUT  = '0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] abyte,
                                      input logic [STRAP_W-1:0] strap);
        return abyte[BYTE_W-1:1] == {DEV_PREFIX, strap};
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2ct_events.sv
module i2ct_events
    import i2ct_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic [SEL_W-1:0]   sel,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               rd_ack
);
    eng_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              mack;
    logic              full;

    assign full = (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            sel     <= SEL_INPUT;
            wr_en   <= 1'b0;
            wr_data <= '0;
            rd_ack  <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            rd_ack <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.scl_rise) begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDAT: begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + CNT_W'(1);
                    end
                    ST_RDAT: cnt <= cnt + CNT_W'(1);
                    ST_WACK: begin
                        if (sel != SEL_INPUT) begin
                            wr_en   <= 1'b1;
                            wr_data <= shreg;
                        end
                    end
                    ST_RACK: begin
                        rd_ack <= 1'b1;
                        mack   <= ~ev.sda;
                    end
                    default: ;
                endcase
            end else if (ev.scl_fall) begin
                case (state)
                    ST_ADDR: begin
                        if (full) begin
                            if (addr_hit(shreg, strap)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_AACK;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (full) begin
                            sda_oe <= 1'b1;
                            sel    <= shreg[SEL_W-1:0];
                            state  <= ST_CACK;
                        end
                    end
                    ST_WDAT: begin
                        if (full) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                        end
                    end
                    ST_AACK: begin
                        cnt <= '0;
                        if (rw) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_CMD;
                        end
                    end
                    ST_CACK, ST_WACK: begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        state  <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        if (full) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        cnt <= '0;
                        if (mack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: a register write lands while SCL is still high in the ACK clock
    p_wr_in_high_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ev.scl);

    // R9: the read strobe lands while SCL is high in the ACK/NACK clock
    p_rdack_in_high_r9: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> ev.scl);

    // R3: an unaddressed target keeps the line released
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R10: a Stop always leaves the line released
    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> !sda_oe);

    // R5: write and read strobes never coincide
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, rd_ack}));
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic               sda_oe,
    output logic [SEL_W-1:0]   reg_sel,
    output logic               reg_wr_en,
    output logic [BYTE_W-1:0]  reg_wr_data,
    input  logic [BYTE_W-1:0]  reg_rd_data,
    output logic               reg_rd_ack
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    bus_ev_t          ev;

    assign raw_lines = {sda_in, scl_in};

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            i2ct_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(1'b1)
            ) u_sync (
                .clk(clk),
                .rst(rst),
                .d  (raw_lines[i]),
                .q  (sync_lines[i])
            );
        end
    endgenerate

    i2ct_events u_events (
        .clk  (clk),
        .rst  (rst),
        .scl_s(sync_lines[0]),
        .sda_s(sync_lines[1]),
        .ev   (ev)
    );

    i2ct_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (strap_addr),
        .rd_data(reg_rd_data),
        .sda_oe (sda_oe),
        .sel    (reg_sel),
        .wr_en  (reg_wr_en),
        .wr_data(reg_wr_data),
        .rd_ack (reg_rd_ack)
    );

    // R11: the target starts pulling SDA low only while synchronized SCL is low
    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !sync_lines[0]);
endmodule

// File: tb/i2ct_target_test.sv
module i2ct_target_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic [1:0] reg_sel;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic       reg_rd_ack;
    logic       bus_sda;

    logic [7:0] regs [4];
    logic [7:0] pin_val = 8'hA7;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int oe_rises = 0;
    bit finished = 0;
    logic prev_oe = 1'b0;
    logic [9:0] wq [$];

    always #4 clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;
    assign reg_rd_data = (reg_sel == 2'd0) ? pin_val : regs[reg_sel];

    i2ct_target uut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (bus_sda),
        .strap_addr (strap),
        .sda_oe     (sda_oe),
        .reg_sel    (reg_sel),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data),
        .reg_rd_ack (reg_rd_ack)
    );

    // register side of the environment
    always @(posedge clk) begin
        if (rst) begin
            regs[0] <= 8'h00; regs[1] <= 8'hFF; regs[2] <= 8'h00; regs[3] <= 8'hFF;
        end else if (reg_wr_en) begin
            regs[reg_sel] <= reg_wr_data;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                wq.push_back({reg_sel, reg_wr_data});
                chk("R6 write strobe inside SCL high", scl_m, 1);
            end
            if (reg_rd_ack) begin
                rd_cnt++;
                chk("R9 read strobe inside SCL high", scl_m, 1);
            end
            if (sda_oe && !prev_oe) begin
                oe_rises++;
                chk("R11 sda_oe rises with SCL low", scl_m, 0);
            end
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        tick(2);
        sda_m = b;
        tick(HALF - 2);
        scl_m = 1'b1;
        tick(HALF / 2);
        seen = bus_sda;
        tick(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(2);
        sda_m = 1'b1;
        tick(HALF);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~give_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int base_rd;
        int base_oe;
        logic [9:0] e;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 wr_en", reg_wr_en, 0);
        chk("R1 rd_ack", reg_rd_ack, 0);
        chk("R1 reg_sel", reg_sel, 0);

        // R2/R8: read with no command byte returns register 0 (pins)
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b1}, a);
        chk("R2 address ack", a, 1);
        base_rd = rd_cnt;
        read_byte(1'b0, d);
        chk("R8 read without command", d, 8'hA7);
        tick(3);
        chk("R10 released after NACK", sda_oe, 0);
        bus_stop();
        chk("R9 one strobe per byte", rd_cnt - base_rd, 1);

        // R3: mismatched address
        base_oe = oe_rises;
        bus_start();
        send_byte({4'b0100, 3'b100, 1'b0}, a);
        chk("R3 no ack on mismatch", a, 0);
        send_byte(8'h01, a);
        chk("R3 command ignored", a, 0);
        send_byte(8'h55, a);
        chk("R3 data ignored", a, 0);
        bus_stop();
        chk("R3 never drove SDA", oe_rises - base_oe, 0);
        chk("R3 no strobes", wq.size(), 0);
        chk("R3 selection unchanged", reg_sel, 0);

        // R4/R5: command with upper bits set, three data bytes to output reg
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b0}, a);
        chk("R2 write address ack", a, 1);
        send_byte(8'hFD, a);
        chk("R4 command ack", a, 1);
        chk("R4 selection from low bits", reg_sel, 1);
        send_byte(8'h12, a);
        chk("R5 data ack", a, 1);
        send_byte(8'h34, a);
        send_byte(8'h56, a);
        bus_stop();
        chk("R5 strobe count", wq.size(), 3);
        e = wq.pop_front(); chk("R5 byte 1", e, {2'd1, 8'h12});
        e = wq.pop_front(); chk("R5 byte 2", e, {2'd1, 8'h34});
        e = wq.pop_front(); chk("R5 byte 3", e, {2'd1, 8'h56});

        // R8: repeated Start keeps the pointer, multi-byte read of one register
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b0}, a);
        send_byte(8'h02, a);
        send_byte(8'h0F, a);
        chk("R5 polarity write", wq.size(), 1);
        void'(wq.pop_front());
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b1}, a);
        chk("R2 read after repeated start", a, 1);
        base_rd = rd_cnt;
        read_byte(1'b1, d); chk("R8 read byte 1", d, 8'h0F);
        read_byte(1'b1, d); chk("R8 read byte 2", d, 8'h0F);
        read_byte(1'b0, d); chk("R8 read byte 3", d, 8'h0F);
        tick(3);
        chk("R10 released after final NACK", sda_oe, 0);
        bus_stop();
        chk("R9 three strobes", rd_cnt - base_rd, 3);

        // R7: write to input register acked but not strobed
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h99, a);
        chk("R7 input write acked", a, 1);
        bus_stop();
        chk("R7 no strobe for input register", wq.size(), 0);
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b1}, a);
        read_byte(1'b0, d);
        bus_stop();
        chk("R7 input read still pins", d, 8'hA7);

        // R8: pointer kept across separate transactions
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b0}, a);
        send_byte(8'h03, a);
        send_byte(8'h81, a);
        bus_stop();
        void'(wq.pop_front());
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b1}, a);
        read_byte(1'b0, d);
        bus_stop();
        chk("R8 config read in new transaction", d, 8'h81);
        chk("R4 selection holds", reg_sel, 3);

        // R2/R3 with a different strap setting
        strap = 3'b000;
        tick(4);
        bus_start();
        send_byte({4'b0100, 3'b101, 1'b1}, a);
        chk("R3 old address rejected", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b0100, 3'b000, 1'b1}, a);
        chk("R2 strap 000 address ack", a, 1);
        read_byte(1'b0, d);
        chk("R8 read under new strap", d, 8'h81);
        bus_stop();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule